// File: doc/BRIEF.md
# Quadword-Selecting Carry-less Multiplier

This block multiplies two 64-bit quadwords as polynomials over GF(2) and returns the full 128-bit product. Partial products are combined with XOR only, so no carry ever moves from one bit position to the next. It serves as the core step of binary-field arithmetic, for example in a hash over GF(2^128). Reduction modulo a field polynomial is left to the logic that uses the product.

The two factors come from two 128-bit source operands, one quadword from each. An 8-bit immediate picks the lower or upper half of each source. A request is presented with `in_valid`. The product appears three clock cycles later with `out_valid`. A new request can be accepted in every cycle, and the latency never depends on the operand values.

The multiplier is pipelined. The first stage registers the two selected quadwords. The second stage forms the partial products in groups of rows and registers one XOR sum per group. The third stage folds the group sums together into the result register.

Top module: `clmul_quad`

## Requirements
- R1: For every accepted request, `result` equals the carry-less product of the selected quadwords A and B. Bit k of `result` is the XOR, over all j from 0 to 63 with 0 <= k-j <= 63, of A[j] AND B[k-j].
- R2: Immediate bit 0 chooses the factor from `src1`. A value of 0 takes `src1[63:0]` and a value of 1 takes `src1[127:64]`.
- R3: Immediate bit 4 chooses the factor from `src2`. A value of 0 takes `src2[63:0]` and a value of 1 takes `src2[127:64]`.
- R4: Immediate bits 1, 2, 3, 5, 6 and 7 have no effect on `result`.
- R5: Bit 127 of `result` is zero whenever `out_valid` is high.
- R6: `out_valid` rises exactly 3 cycles after the cycle in which `in_valid` is sampled high, for any operand values. Requests presented in consecutive cycles give results in consecutive cycles, in the same order.
- R7: While `rst_n` is low, `out_valid` is low and `result` is zero. After `rst_n` rises, the block needs two clock edges before it accepts a request.
- R8: Multiplying 0x63746f725d53475d by 0x5b477565726f6e5d gives 0x1d4d84c85c3440c0929633d5d36f0451.
- R9: A zero factor gives a zero result. Two all-ones factors give a result with bits 126..0 set to the alternating pattern of an all-ones polynomial square.
- R10: When `out_valid` is low, `result` keeps the value of the last product delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised internally on release |
| in_valid | input | 1 | Request strobe: the sources and immediate are sampled when high |
| src1 | input | 128 | First source operand, two quadwords |
| src2 | input | 128 | Second source operand, two quadwords |
| imm | input | 8 | Selector byte: bit 0 picks the half of `src1`, bit 4 picks the half of `src2` |
| out_valid | output | 1 | High for one cycle per product |
| result | output | 128 | Carry-less product, held between products |

## Verification
A fault in the operand registers or in a group accumulator shows up as wrong bits in the very product that passes through it. The bench sees this three cycles after the request and compares it against a bit-serial shift-and-XOR model. A fault in the select path appears only for some immediate values, so all four half combinations and values with the ignored bits set are driven. A broken valid pipeline shows up as a product that arrives a cycle early or late. The bench catches this because it stamps each request with its issue cycle.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  // Half of a 128-bit source operand that feeds the multiplier
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  // Immediate bit positions that steer the two operand selects
  localparam int SEL_SRC1_BIT = 0;
  localparam int SEL_SRC2_BIT = 4;

  // Pipeline depth from request to product
  localparam int PIPE_LAT = 3;
endpackage

// File: rtl/clmul_rst_sync.sv
module clmul_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/clmul_qw_select.sv
module clmul_qw_select
  import clmul_pkg::*;
#(
  parameter int QW_W = 64
) (
  input  logic [2*QW_W-1:0] src,
  input  half_e             half,
  output logic [QW_W-1:0]   qw
);
  always_comb begin
    if (half == HALF_HI) qw = src[2*QW_W-1:QW_W];
    else                 qw = src[QW_W-1:0];
  end
endmodule

// File: rtl/clmul_group_accum.sv
module clmul_group_accum #(
  parameter int QW_W  = 64,
  parameter int FIRST = 0,
  parameter int ROWS  = 16
) (
  input  logic [QW_W-1:0]   a,
  input  logic [ROWS-1:0]   b_slice,
  output logic [2*QW_W-1:0] psum
);
  localparam int PROD_W = 2 * QW_W;

  logic [PROD_W-1:0] a_wide;
  assign a_wide = {{QW_W{1'b0}}, a};

  // XOR of the shifted copies of a for the rows owned by this group
  always_comb begin
    psum = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (b_slice[r]) psum = psum ^ (a_wide << (FIRST + r));
    end
  end
endmodule

// File: rtl/clmul_quad.sv
module clmul_quad
  import clmul_pkg::*;
#(
  parameter int QW_W   = 64,
  parameter int NGROUP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2*QW_W-1:0]   src1,
  input  logic [2*QW_W-1:0]   src2,
  input  logic [7:0]          imm,
  output logic                out_valid,
  output logic [2*QW_W-1:0]   result
);
  localparam int PROD_W = 2 * QW_W;
  localparam int ROWS   = QW_W / NGROUP;

  logic rst_sync_n;

  clmul_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Immediate decode: only two bits steer the selects
  half_e sel1, sel2;
  logic  unused_imm_bits;
  assign sel1 = half_e'(imm[SEL_SRC1_BIT]);
  assign sel2 = half_e'(imm[SEL_SRC2_BIT]);
  assign unused_imm_bits = ^{imm[7:5], imm[3:1]};

  logic [QW_W-1:0] a_sel, b_sel;

  clmul_qw_select #(.QW_W(QW_W)) u_sel1 (.src(src1), .half(sel1), .qw(a_sel));
  clmul_qw_select #(.QW_W(QW_W)) u_sel2 (.src(src2), .half(sel2), .qw(b_sel));

  // Stage 1: selected operands
  logic            s1_valid_q;
  logic [QW_W-1:0] s1_a_q, s1_b_q;
  logic            s1_en;
  assign s1_en = in_valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid_q <= 1'b0;
      s1_a_q     <= '0;
      s1_b_q     <= '0;
    end else begin
      s1_valid_q <= in_valid;
      if (s1_en) begin
        s1_a_q <= a_sel;
        s1_b_q <= b_sel;
      end
    end
  end

  // Stage 2: one registered partial sum per row group
  logic              s2_valid_q;
  logic              s2_en;
  logic [PROD_W-1:0] grp_d [NGROUP];
  logic [PROD_W-1:0] grp_q [NGROUP];
  assign s2_en = s1_valid_q;

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    clmul_group_accum #(
      .QW_W  (QW_W),
      .FIRST (g * ROWS),
      .ROWS  (ROWS)
    ) u_acc (
      .a       (s1_a_q),
      .b_slice (s1_b_q[g*ROWS +: ROWS]),
      .psum    (grp_d[g])
    );

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)  grp_q[g] <= '0;
      else if (s2_en)   grp_q[g] <= grp_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) s2_valid_q <= 1'b0;
    else             s2_valid_q <= s1_valid_q;
  end

  // Stage 3: fold the group sums
  logic [PROD_W-1:0] fold_d;
  logic              s3_en;
  assign s3_en = s2_valid_q;

  always_comb begin
    fold_d = '0;
    for (int g = 0; g < NGROUP; g++) fold_d = fold_d ^ grp_q[g];
  end

  logic              out_valid_q;
  logic [PROD_W-1:0] result_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid_q <= 1'b0;
      result_q    <= '0;
    end else begin
      out_valid_q <= s2_valid_q;
      if (s3_en) result_q <= fold_d;
    end
  end

  assign out_valid = out_valid_q;
  assign result    = result_q;
endmodule

// File: rtl/clmul_quad_chk.sv
module clmul_quad_chk #(
  parameter int QW_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic [2*QW_W-1:0] result
);
  // Top product bit can never be set
  assert_top_bit_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !result[2*QW_W-1]);

  // Each request produces a product three cycles later
  assert_latency_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  // No product appears without a matching request
  assert_latency_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  // Reset keeps the output strobe low
  assert_reset_idle_R7: assert property (@(posedge clk)
    !rst_n |-> !out_valid);

  // Result holds between products
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result));
endmodule

bind clmul_quad clmul_quad_chk #(.QW_W(QW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/clmul_quad_tb.sv
module clmul_quad_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;
  localparam int WATCHDOG = 20000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b1;
  logic           in_valid = 1'b0;
  logic [2*W-1:0] src1 = '0;
  logic [2*W-1:0] src2 = '0;
  logic [7:0]     imm = '0;
  logic           out_valid;
  logic [2*W-1:0] result;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  logic [2*W-1:0] exp_q [$];
  string          tag_q [$];
  int             cyc_q [$];
  logic [2*W-1:0] last_result = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clmul_quad u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src1(src1), .src2(src2), .imm(imm),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] acc = '0;
    logic [2*W-1:0] sh  = {{W{1'b0}}, a};
    for (int i = 0; i < W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh << 1;
    end
    return acc;
  endfunction

  task automatic check(input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: present one request and push its expected product (R2, R3 select rule)
  task automatic drive(input logic [2*W-1:0] s1, input logic [2*W-1:0] s2,
                       input logic [7:0] im, input string tag);
    logic [W-1:0] a, b;
    @(negedge clk);
    in_valid = 1'b1; src1 = s1; src2 = s2; imm = im;
    a = im[0] ? s1[2*W-1:W] : s1[W-1:0];
    b = im[4] ? s2[2*W-1:W] : s2[W-1:0];
    exp_q.push_back(ref_mul(a, b));
    tag_q.push_back(tag);
    cyc_q.push_back(cyc);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compare each product, its latency (R6) and its top bit (R5)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected out_valid", {127'b0, out_valid}, '0);
      end else begin
        automatic logic [2*W-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        automatic int c0 = cyc_q.pop_front();
        check(t, result, e);
        check("R6 latency", 128'(cyc - c0), 128'(3));
        check("R5 bit127", {127'b0, result[2*W-1]}, '0);
        last_result = result;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset out_valid", {127'b0, out_valid}, '0);
    check("R7 reset result", result, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 idle after release", {127'b0, out_valid}, '0);

    // R8 known vector, src1 low and src2 high
    drive({64'h0, 64'h63746f725d53475d}, {64'h5b477565726f6e5d, 64'h0}, 8'h10, "R8 known vector");
    idle();
    repeat (4) @(negedge clk);
    check("R8 literal", last_result, 128'h1d4d84c85c3440c0929633d5d36f0451);

    // R2, R3: all four half combinations with distinct quadwords
    for (int s = 0; s < 4; s++) begin
      drive({64'hf00d_1234_abcd_0001, 64'h0000_0000_0000_00ff},
            {64'h8000_0000_0000_0003, 64'h1357_9bdf_2468_ace0},
            {3'b000, s[1], 3'b000, s[0]}, "R2 R3 half select");
    end
    // R4: ignored bits set in every combination
    drive({64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210}, {64'h5555_aaaa_5555_aaaa, 64'h0f0f_f0f0_0f0f_f0f0}, 8'hEE, "R4 ignored bits lo lo");
    drive({64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210}, {64'h5555_aaaa_5555_aaaa, 64'h0f0f_f0f0_0f0f_f0f0}, 8'hFF, "R4 ignored bits hi hi");
    drive({64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210}, {64'h5555_aaaa_5555_aaaa, 64'h0f0f_f0f0_0f0f_f0f0}, 8'hEF, "R4 ignored bits hi lo");
    // R9 corner operands
    drive({64'h0, 64'hdead_beef_cafe_f00d}, {64'h0, 64'h0}, 8'h00, "R9 zero factor");
    drive({64'hffff_ffff_ffff_ffff, 64'h0}, {64'hffff_ffff_ffff_ffff, 64'h0}, 8'h11, "R9 all ones");
    drive({64'h8000_0000_0000_0000, 64'h0}, {64'h0, 64'h8000_0000_0000_0000}, 8'h01, "R5 R9 top bits");
    // R1, R6: back-to-back random stream
    for (int i = 0; i < 40; i++) begin
      drive({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
            8'($urandom), "R1 R6 random stream");
    end
    idle();
    // R6: spaced requests
    for (int i = 0; i < 5; i++) begin
      drive({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
            8'($urandom), "R1 R6 spaced");
      idle();
      idle();
    end
    repeat (6) @(negedge clk);
    check("R6 queue drained", 128'(exp_q.size()), '0);
    // R10: result held while idle
    repeat (5) @(negedge clk);
    check("R10 hold", result, last_result);
    check("R10 out_valid low", {127'b0, out_valid}, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule